// File: doc/BRIEF.md
# Banked Shared Memory Conflict Resolver

This block serves one group-wide read of a banked on-chip scratch memory. A request carries one word address and one enable bit for each of 32 lanes. The memory is split into 32 banks by the low address bits. Each bank can return one word per cycle.

The resolver splits the request into as few passes as possible. When several lanes ask for the same word, that word is fetched once and handed to all of them. Only lanes asking for different words of the same bank are pushed into later passes. The number of passes is therefore the largest number of distinct words requested from any single bank.

In every pass the block drives an enable and a row address to each bank. One cycle later it captures the returned words into the lanes that were served. When all active lanes have their data, it pulses `done`. The full result vector and the pass count are valid in that cycle. A new request is taken only while the block is idle.

Top module: `sm_conflict_resolver`

## Requirements
- R1: A word address `w` maps to bank `w[4:0]` (w mod 32) and row `w[9:5]`. A bank is read by raising its bit of `bank_en` and putting the row in field `bank_addr[b*5 +: 5]`.
- R2: Lanes that request the same word are served together in a single pass, so a request whose lanes ask for one word, or for at most one word per bank, completes in one pass.
- R3: Lanes that request different words of the same bank are served in separate passes. `pass_count` equals the largest count of distinct words requested from any one bank among active lanes.
- R4: In each pass, each bank is read at the word wanted by the lowest-numbered active lane that maps to it and is not yet served.
- R5: Bank read data arrives one cycle after the bank address. Each active lane's result holds the data of the word it addressed.
- R6: `done` is a one-cycle pulse. It rises exactly `pass_count + 2` cycles after the accepting cycle, and `result` and `pass_count` are valid while it is high.
- R7: Lanes with their mask bit low return zero, and their addresses do not affect the pass count. An all-zero mask completes with a pass count of 0.
- R8: `req_ready` is high only while idle, which includes the `done` cycle. A request held valid while the block is busy is ignored.
- R9: After reset, `req_ready` is high, `done` is low and no bank is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_mask | input | LANES (32) | Active lane bits |
| req_addr | input | LANES*ADDR_W (320) | Word address per lane, lane l at `[l*10 +: 10]` |
| bank_en | output | BANKS (32) | Read enable per bank |
| bank_addr | output | BANKS*ROW_W (160) | Row address per bank |
| bank_rdata | input | BANKS*DATA_W (1024) | Read data per bank, one cycle after enable |
| done | output | 1 | Completion pulse |
| result | output | LANES*DATA_W (1024) | Read data per lane |
| pass_count | output | CNT_W (6) | Number of passes used |

## Verification
The bench uses two stride patterns to tell a true bank conflict from a broadcast. A lane-mod-16 pattern needs one pass, while folding lanes 16..31 onto words 32..47 needs two. A padded column stride of 33 touches every bank once, and a plain stride of 32 puts all 32 lanes on bank 0 and forces 32 passes. It also tries all lanes on one word, an empty mask, and sparse masks whose inactive lanes would conflict if they were counted. A case where three lanes out of index order hit the same bank checks the lowest-lane choice in the first pass. Pseudo-random addresses over a few rows cover mixed conflict depths, with bank addresses, per-lane data, pass count and latency compared for every request.

// File: rtl/sm_cr_pkg.sv
package sm_cr_pkg;

    localparam int LANES_DEF  = 32;
    localparam int BANKS_DEF  = 32;
    localparam int ADDR_W_DEF = 10;
    localparam int DATA_W_DEF = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rs_state_t;

endpackage

// File: rtl/sm_bank_pick.sv
// Chooses, for one bank, the word wanted by the lowest pending lane mapped to it.
module sm_bank_pick #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 10,
    parameter int BANK_W  = 5,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    output logic                    pick_en,
    output logic [ROW_W-1:0]        pick_row
);

    always_comb begin
        pick_en  = 1'b0;
        pick_row = '0;
        // Walk downward so the lowest matching lane is the last to write.
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pending[l] &&
                lane_addr[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID)) begin
                pick_en  = 1'b1;
                pick_row = lane_addr[l*ADDR_W + BANK_W +: ROW_W];
            end
        end
    end

endmodule

// File: rtl/sm_lane_capture.sv
// Result register per lane, loaded from its bank one cycle after issue.
module sm_lane_capture #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [LANES-1:0]        cap_mask,
    input  logic [LANES*BANK_W-1:0] lane_bank,
    input  logic [BANKS*DATA_W-1:0] bank_rdata,
    output logic [LANES*DATA_W-1:0] result
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BANK_W-1:0] sel;
        assign sel = lane_bank[l*BANK_W +: BANK_W];

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                result[l*DATA_W +: DATA_W] <= '0;
            end else if (cap_mask[l]) begin
                result[l*DATA_W +: DATA_W] <= bank_rdata[sel*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/sm_conflict_resolver.sv
module sm_conflict_resolver
    import sm_cr_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int BANKS  = BANKS_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic [BANKS-1:0]        bank_en,
    output logic [BANKS*ROW_W-1:0]  bank_addr,
    input  logic [BANKS*DATA_W-1:0] bank_rdata,
    output logic                    done,
    output logic [LANES*DATA_W-1:0] result,
    output logic [CNT_W-1:0]        pass_count
);

    rs_state_t               state;
    logic [LANES-1:0]        pending;
    logic [LANES-1:0]        served;
    logic [LANES-1:0]        cap_mask;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES*BANK_W-1:0] lane_bank;
    logic [CNT_W-1:0]        passes;
    logic                    done_q;
    logic                    run;
    logic                    accept;

    logic [BANKS-1:0]        pick_en;
    logic [ROW_W-1:0]        pick_row [BANKS];

    assign run    = (state == ST_RUN);
    assign accept = (state == ST_IDLE) && req_valid;

    // One picker per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sm_bank_pick #(
            .LANES  (LANES),
            .ADDR_W (ADDR_W),
            .BANK_W (BANK_W),
            .BANK_ID(b)
        ) u_pick (
            .pending  (pending),
            .lane_addr(addr_q),
            .pick_en  (pick_en[b]),
            .pick_row (pick_row[b])
        );
        assign bank_en[b]                   = run & pick_en[b];
        assign bank_addr[b*ROW_W +: ROW_W]  = run ? pick_row[b] : '0;
    end

    // A lane is served when its bank reads exactly its row this pass.
    for (genvar l = 0; l < LANES; l++) begin : g_match
        logic [BANK_W-1:0] lb;
        logic [ROW_W-1:0]  lr;
        assign lb = addr_q[l*ADDR_W +: BANK_W];
        assign lr = addr_q[l*ADDR_W + BANK_W +: ROW_W];
        assign lane_bank[l*BANK_W +: BANK_W] = lb;
        assign served[l] = pending[l] && pick_en[lb] && (pick_row[lb] == lr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pending  <= '0;
            addr_q   <= '0;
            cap_mask <= '0;
            passes   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            cap_mask <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pending <= req_mask;
                        addr_q  <= req_addr;
                        passes  <= '0;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cap_mask <= served;
                    pending  <= pending & ~served;
                    if (|pending) begin
                        passes <= passes + CNT_W'(1);
                    end else begin
                        // Last pass data is captured at this same edge.
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sm_lane_capture #(
        .LANES (LANES),
        .BANKS (BANKS),
        .DATA_W(DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .cap_mask  (cap_mask),
        .lane_bank (lane_bank),
        .bank_rdata(bank_rdata),
        .result    (result)
    );

    assign req_ready  = (state == ST_IDLE);
    assign done       = done_q;
    assign pass_count = passes;

endmodule

// File: rtl/sm_conflict_resolver_chk.sv
module sm_conflict_resolver_chk #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [LANES-1:0]        req_mask,
    input logic [BANKS-1:0]        bank_en,
    input logic                    done,
    input logic [LANES*DATA_W-1:0] result,
    input logic [CNT_W-1:0]        pass_count
);

    logic [LANES-1:0] mask_q;
    logic             inact_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (req_valid && req_ready) begin
            mask_q <= req_mask;
        end
    end

    always_comb begin
        inact_bad = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (!mask_q[l] && result[l*DATA_W +: DATA_W] != '0) begin
                inact_bad = 1'b1;
            end
        end
    end

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_inactive_zero_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !inact_bad);

    assert_pass_bound_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(pass_count) <= 32'($countones(mask_q))));

    assert_first_issue_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (|req_mask)) |=> (|bank_en));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bank_en == '0));

endmodule

bind sm_conflict_resolver sm_conflict_resolver_chk #(
    .LANES (LANES),
    .BANKS (BANKS),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .bank_en   (bank_en),
    .done      (done),
    .result    (result),
    .pass_count(pass_count)
);

// File: tb/sim_sm_conflict_resolver.sv
module sim_sm_conflict_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int ROW_W  = 5;
    localparam int CNT_W  = 6;
    localparam int ROWS   = 1 << ROW_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES-1:0]        req_mask = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [BANKS-1:0]        bank_en;
    logic [BANKS*ROW_W-1:0]  bank_addr;
    logic [BANKS*DATA_W-1:0] bank_rdata = '0;
    logic                    done;
    logic [LANES*DATA_W-1:0] result;
    logic [CNT_W-1:0]        pass_count;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit closed = 1'b0;
    int unsigned rng = 32'h1234_5678;

    typedef struct {
        logic [LANES*DATA_W-1:0] res;
        int                      passes;
        int                      acc;
        string                   name;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sm_conflict_resolver u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .bank_en(bank_en),
        .bank_addr(bank_addr), .bank_rdata(bank_rdata), .done(done),
        .result(result), .pass_count(pass_count)
    );

    function automatic logic [DATA_W-1:0] memf(int unsigned w);
        return DATA_W'((w * 32'h0001_0001) ^ 32'hC3C3_0000);
    endfunction

    // Bank memory: one-cycle read latency.
    always_ff @(posedge clk) begin
        for (int b = 0; b < BANKS; b++) begin
            if (bank_en[b]) begin
                bank_rdata[b*DATA_W +: DATA_W] <=
                    memf(int'(bank_addr[b*ROW_W +: ROW_W]) * BANKS + b);
            end
        end
    end

    function automatic int unsigned next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    task automatic chk(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic send(input int unsigned a [LANES], input logic [LANES-1:0] m,
                        input bit hold, input string name);
        exp_t e;
        bit   seen [BANKS][ROWS];
        int   cnt;
        int   worst;
        bit   en_x  [BANKS];
        int   row_x [BANKS];
        worst = 0;
        for (int b = 0; b < BANKS; b++) begin
            en_x[b] = 1'b0;
            row_x[b] = 0;
            for (int r = 0; r < ROWS; r++) seen[b][r] = 1'b0;
        end
        for (int l = 0; l < LANES; l++) begin
            if (m[l]) seen[a[l] % BANKS][a[l] / BANKS] = 1'b1;
        end
        for (int b = 0; b < BANKS; b++) begin
            cnt = 0;
            for (int r = 0; r < ROWS; r++) cnt += int'(seen[b][r]);
            if (cnt > worst) worst = cnt;
        end
        for (int l = LANES - 1; l >= 0; l--) begin
            e.res[l*DATA_W +: DATA_W] = m[l] ? memf(a[l]) : '0;
            if (m[l]) begin
                en_x[a[l] % BANKS]  = 1'b1;
                row_x[a[l] % BANKS] = int'(a[l] / BANKS);
            end
        end
        e.passes = worst;
        e.name   = name;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_mask  = m;
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(a[l]);
        e.acc = cyc;
        exp_q.push_back(e);

        @(negedge clk);
        // First pass: bank mapping (R1) and lowest-lane choice (R4).
        for (int b = 0; b < BANKS; b++) begin
            chk(bank_en[b] == en_x[b], "R1",
                $sformatf("%s bank %0d enable act=%0b exp=%0b", name, b, bank_en[b], en_x[b]));
            if (en_x[b]) begin
                chk(int'(bank_addr[b*ROW_W +: ROW_W]) == row_x[b], "R4",
                    $sformatf("%s bank %0d row act=%0d exp=%0d", name, b,
                              bank_addr[b*ROW_W +: ROW_W], row_x[b]));
            end
        end
        chk(!req_ready, "R8", $sformatf("%s ready while busy act=%0b exp=0", name, req_ready));
        if (hold) begin
            // Keep a different request valid while busy: it must be ignored (R8).
            req_mask = '1;
            req_addr = '0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!req_ready, "R8", $sformatf("%s ready during hold act=%0b exp=0",
                                                name, req_ready));
            end
        end
        req_valid = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected done act=1 exp=0");
            end else begin
                exp_t e;
                int   bad;
                e = exp_q.pop_front();
                bad = -1;
                for (int l = LANES - 1; l >= 0; l--) begin
                    if (result[l*DATA_W +: DATA_W] !== e.res[l*DATA_W +: DATA_W]) bad = l;
                end
                if (bad >= 0) begin
                    chk(1'b0, "R5/R7", $sformatf("%s lane %0d data act=%h exp=%h", e.name, bad,
                        result[bad*DATA_W +: DATA_W], e.res[bad*DATA_W +: DATA_W]));
                end else begin
                    chk(1'b1, "R5", "");
                end
                chk(int'(pass_count) == e.passes, "R3",
                    $sformatf("%s passes act=%0d exp=%0d", e.name, pass_count, e.passes));
                chk(cyc - e.acc == e.passes + 2, "R6",
                    $sformatf("%s latency act=%0d exp=%0d", e.name, cyc - e.acc, e.passes + 2));
            end
        end
    end

    task automatic finish_run();
        if (!closed) begin
            closed = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        int unsigned a [LANES];
        logic [LANES-1:0] m;

        repeat (3) @(negedge clk);
        chk(req_ready && !done && bank_en == '0, "R9",
            $sformatf("in reset ready=%0b done=%0b en=%h exp 1/0/0", req_ready, done, bank_en));
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && bank_en == '0, "R9",
            $sformatf("after reset ready=%0b done=%0b en=%h exp 1/0/0", req_ready, done, bank_en));

        // R2: lane mod 16, pairs broadcast
        for (int l = 0; l < LANES; l++) a[l] = l % 16;
        send(a, '1, 1'b0, "mod16");
        // R3: upper half folded onto words 32..47 -> two passes
        for (int l = 0; l < LANES; l++) a[l] = (l % 16) + 32 * (l / 16);
        send(a, '1, 1'b0, "fold64");
        // R2: padded column stride
        for (int l = 0; l < LANES; l++) a[l] = l * 33;
        send(a, '1, 1'b0, "stride33");
        // R3/R8: all on bank 0, with a request held during busy
        for (int l = 0; l < LANES; l++) a[l] = l * 32;
        send(a, '1, 1'b1, "stride32");
        // R2: every lane on one word
        for (int l = 0; l < LANES; l++) a[l] = 77;
        send(a, '1, 1'b0, "same");
        // R7: empty mask
        for (int l = 0; l < LANES; l++) a[l] = l * 32;
        send(a, '0, 1'b0, "empty");
        // R7: inactive odd lanes would conflict
        for (int l = 0; l < LANES; l++) a[l] = (l % 2 == 1) ? l * 32 : l;
        send(a, 32'h5555_5555, 1'b0, "sparse");
        // R4: lanes 3, 5, 9 all on bank 0 -> first pass row 1
        for (int l = 0; l < LANES; l++) a[l] = 0;
        a[3] = 32; a[5] = 64; a[9] = 0;
        send(a, 32'h0000_0228, 1'b0, "order");
        // Mixed random conflict depths
        for (int k = 0; k < 8; k++) begin
            for (int l = 0; l < LANES; l++) a[l] = next_rand() % 128;
            m = next_rand();
            send(a, m, 1'b0, $sformatf("rand%0d", k));
        end

        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6", $sformatf("outstanding act=%0d exp=0", exp_q.size()));
        finish_run();
    end

endmodule